// File: doc/BRIEF.md
# Interrupt Pin Qualifier

The block watches four external interrupt inputs and turns each qualified assertion into a single-cycle pending pulse for that pin. A pin is only accepted after a minimum run of deasserted samples followed by a minimum run of asserted samples. The run length depends on a mode bit: one sample each in synchronous mode, and two each in asynchronous mode. In asynchronous mode the pins are first passed through a two-flop synchronizer. Throughout, a level of 1 on a pin input means asserted.

A small control register sets how the pins are used. It picks the qualification mode. It can turn pin 2 into a request line from an external interrupt controller, in which case qualified assertions appear on a separate output. It can also turn pin 3 into an acknowledge output. In that mode pin 3's input qualification is switched off, and an open-drain pull-low enable is driven from a latched acknowledge value.

While reset is held, pin 0 is read as a strap that sets the local processor number, and that value is kept until the next reset. Prioritization, servicing and the acknowledge bus cycle itself belong to surrounding logic.

Top module: `irq_pin_qual`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `irq_pend`, `ext_req_pulse` and `p3_pull_low` are 0. The control register resets to 0, which means synchronous mode, pin 2 as a generic interrupt and pin 3 as an input.
- R2: In synchronous mode, a pin that was 0 at one or more clock edges and is then driven to 1 raises its `irq_pend` bit in the second cycle after the first edge that samples the 1.
- R3: In asynchronous mode, a pin must be 0 at two or more consecutive edges and then 1 at two or more consecutive edges. The pulse then appears in the fourth cycle after the first edge that samples the 1. A single low sample or a single high sample produces no pulse.
- R4: Each qualified assertion gives exactly one pulse. A pin held at 1 gives no further pulse until it has again met the deasserted minimum.
- R5: Every pulse on `irq_pend` or `ext_req_pulse` lasts exactly one cycle.
- R6: A write with `ctrl_we` high loads `ctrl_wdata` at the clock edge. Bit 0 selects asynchronous mode, bit 1 selects the pin 2 controller-request role, and bit 2 selects the pin 3 acknowledge role.
- R7: With bit 1 set, a qualified assertion on pin 2 pulses `ext_req_pulse` and leaves `irq_pend[2]` at 0. With bit 1 clear it pulses `irq_pend[2]` only.
- R8: With bit 2 set, no activity on `pin_in[3]` produces a pulse. After bit 2 is cleared, pin 3 qualifies like the other pins again.
- R9: `ack_level` is latched at an edge where `ack_load` is high and held otherwise. `p3_pull_low` equals the latched value while bit 2 is set and is 0 while bit 2 is clear.
- R10: `local_num` takes the inverse of `pin_in[0]` as sampled during reset (1 gives 0, 0 gives 1) and holds it until the next reset.
- R11: Pins are qualified independently, so pins that qualify in the same cycle pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 4 | Interrupt pin levels, 1 = asserted |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 3 | Control write data: [0] async, [1] pin 2 request role, [2] pin 3 acknowledge role |
| ack_load | input | 1 | Latch strobe for the acknowledge value |
| ack_level | input | 1 | Acknowledge value to latch |
| irq_pend | output | 4 | Per-pin single-cycle pending pulses |
| ext_req_pulse | output | 1 | Single-cycle pulse for a pin 2 controller request |
| p3_pull_low | output | 1 | Open-drain pull-low enable for pin 3 |
| local_num | output | 1 | Strapped local processor number |

## Verification
The hardest state to reach is an asynchronous-mode pin that is already armed by a long low run but then sees only one high sample before dropping again. The pin must stay armed through the following short low run, and it must pulse only on the next high run that lasts two samples. The bench builds this one cycle at a time (two low, one high, one low, then held high) and expects exactly one pulse, four cycles after the final rise. The strap is reached by reasserting reset mid-run with pin 0 low. Because the pin is still low when reset is released, it arms straight away, and the bench checks the pulse that follows its later rise.

// File: rtl/irq_qual_pkg.sv
// Package: shared constants and the control register layout for the
// interrupt pin qualifier. Assumes exactly four pins, with pin 2 and pin 3
// having the alternate roles.
package irq_qual_pkg;

    localparam int NUM_PINS = 4;
    localparam int PIN_REQ  = 2;
    localparam int PIN_ACK  = 3;
    localparam int CTRL_W   = 3;

    // Control register; bit order matches ctrl_wdata
    typedef struct packed {
        logic p3_ack;     // bit 2: pin 3 drives acknowledge
        logic p2_ext;     // bit 1: pin 2 is controller request
        logic async_en;   // bit 0: asynchronous qualification
    } ctrl_t;

endpackage

// File: rtl/irq_pin_sync.sv
// Two-flop synchronizer bank. Both stages are brought out so that the
// caller can choose one or two stages of delay. Flops reset to 1 (asserted)
// so that a pin starts out unarmed and cannot fake a deasserted run.
module irq_pin_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q1,
    output logic [W-1:0] q2
);

    // Purpose: shift pin levels through two flop stages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q1 <= '1;
            q2 <= '1;
        end else begin
            q1 <= d;
            q2 <= q1;
        end
    end

endmodule

// File: rtl/irq_pin_qualifier.sv
// One-pin qualifier. It counts consecutive low samples until the count
// reaches `need`, which arms the pin. It then counts consecutive high
// samples and emits a registered one-cycle pulse when that count reaches
// `need`. The pulse disarms the pin. Clearing `en` holds all state cleared.
// Assumes `need` is nonzero and fits in CNT_W bits.
module irq_pin_qualifier #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] need,
    input  logic             v,
    output logic             pulse
);

    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] lo_cnt, hi_cnt;
    logic [CNT_W-1:0] lo_nx, hi_nx;
    logic             armed;

    // Purpose: saturating next values of the run counters
    always_comb begin
        lo_nx = (lo_cnt == CMAX) ? CMAX : lo_cnt + 1'b1;
        hi_nx = (hi_cnt == CMAX) ? CMAX : hi_cnt + 1'b1;
    end

    // Purpose: arm on the low run, fire and disarm on the high run
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            lo_cnt <= '0;
            hi_cnt <= '0;
            armed  <= 1'b0;
            pulse  <= 1'b0;
        end else if (!v) begin
            hi_cnt <= '0;
            pulse  <= 1'b0;
            lo_cnt <= lo_nx;
            if (lo_nx >= need) armed <= 1'b1;
        end else begin
            lo_cnt <= '0;
            pulse  <= 1'b0;
            if (armed) begin
                if (hi_nx >= need) begin
                    pulse  <= 1'b1;
                    armed  <= 1'b0;
                    hi_cnt <= '0;
                end else begin
                    hi_cnt <= hi_nx;
                end
            end
        end
    end

endmodule

// File: rtl/irq_ack_latch.sv
// Acknowledge output stage for pin 3. It latches a value on a load strobe
// and holds it. The open-drain pull-low enable is active only while the
// acknowledge role is selected; otherwise the pin is released.
module irq_ack_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic level,
    input  logic ack_mode,
    output logic pull_low
);

    logic ack_q;

    // Purpose: hold the acknowledge value between load strobes
    always_ff @(posedge clk) begin
        if (!rst_n)    ack_q <= 1'b0;
        else if (load) ack_q <= level;
    end

    // Purpose: drive low only in acknowledge role, else release
    always_comb pull_low = ack_mode & ack_q;

endmodule

// File: rtl/irq_pin_qual.sv
// Top of the interrupt pin qualifier. It holds the control register and the
// reset strap, selects the one- or two-stage synchronized view of each pin
// and the minimum run length, runs one qualifier per pin, and routes the
// pin 2 and pin 3 roles. Assumes pins are level inputs with 1 = asserted.
module irq_pin_qual
    import irq_qual_pkg::*;
#(
    parameter int CNT_W     = 2,
    parameter int SYNC_MIN  = 1,
    parameter int ASYNC_MIN = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                ctrl_we,
    input  logic [CTRL_W-1:0]   ctrl_wdata,
    input  logic                ack_load,
    input  logic                ack_level,
    output logic [NUM_PINS-1:0] irq_pend,
    output logic                ext_req_pulse,
    output logic                p3_pull_low,
    output logic                local_num
);

    localparam logic [CNT_W-1:0] NEED_S = CNT_W'(SYNC_MIN);
    localparam logic [CNT_W-1:0] NEED_A = CNT_W'(ASYNC_MIN);

    ctrl_t               ctrl_q;
    logic [NUM_PINS-1:0] s1, s2, v;
    logic [NUM_PINS-1:0] qpulse;
    logic [CNT_W-1:0]    need;

    // Purpose: control register, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_t'(ctrl_wdata);
    end

    // Purpose: sample the pin 0 strap while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) local_num <= ~pin_in[0];
    end

    irq_pin_sync #(.W(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q1    (s1),
        .q2    (s2)
    );

    // Purpose: pick the pin view and the minimum run length for the mode
    always_comb begin
        v    = ctrl_q.async_en ? s2 : s1;
        need = ctrl_q.async_en ? NEED_A : NEED_S;
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic en_i;
        if (i == PIN_ACK) begin : g_ackpin
            assign en_i = ~ctrl_q.p3_ack;
        end else begin : g_plain
            assign en_i = 1'b1;
        end

        irq_pin_qualifier #(.CNT_W(CNT_W)) u_qual (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en_i),
            .need  (need),
            .v     (v[i]),
            .pulse (qpulse[i])
        );

        if (i == PIN_REQ) begin : g_route_req
            assign irq_pend[i] = qpulse[i] & ~ctrl_q.p2_ext;
        end else begin : g_route_std
            assign irq_pend[i] = qpulse[i];
        end
    end

    assign ext_req_pulse = qpulse[PIN_REQ] & ctrl_q.p2_ext;

    irq_ack_latch u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ack_load),
        .level    (ack_level),
        .ack_mode (ctrl_q.p3_ack),
        .pull_low (p3_pull_low)
    );

endmodule

// File: rtl/irq_pin_qual_chk.sv
// Assertion checker for irq_pin_qual, attached with bind. It observes the
// ports and the control register state only.
module irq_pin_qual_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] irq_pend,
    input logic       ext_req_pulse,
    input logic       p3_pull_low,
    input logic       local_num,
    input logic       ctrl_we,
    input logic       ack_load,
    input logic [2:0] ctrl_q
);

    // R5: each pending pulse lasts a single cycle
    for (genvar i = 0; i < 4; i++) begin : g_single
        p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
            irq_pend[i] |=> !irq_pend[i]);
    end

    p_ext_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req_pulse |=> !ext_req_pulse);

    // R8: pin 3 reports nothing once its acknowledge role has settled
    p_p3_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ctrl_q[2] && $past(ctrl_q[2])) |-> !irq_pend[3]);

    // R10: strap holds after reset is released
    p_strap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(local_num));

    // R9: pull-low changes only after a load or a control write
    p_ack_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ack_load) && !$past(ctrl_we)) |-> $stable(p3_pull_low));

endmodule

bind irq_pin_qual irq_pin_qual_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .irq_pend      (irq_pend),
    .ext_req_pulse (ext_req_pulse),
    .p3_pull_low   (p3_pull_low),
    .local_num     (local_num),
    .ctrl_we       (ctrl_we),
    .ack_load      (ack_load),
    .ctrl_q        (ctrl_q)
);

// File: tb/tb_irq_pin_qual.sv
// Scoreboard bench: drivers queue expected pulses with their cycle number,
// and a negedge monitor compares every observed or expected pulse.
module tb_irq_pin_qual;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] pin_in;
    logic       ctrl_we;
    logic [2:0] ctrl_wdata;
    logic       ack_load, ack_level;
    logic [3:0] irq_pend;
    logic       ext_req_pulse, p3_pull_low, local_num;

    int    n_chk = 0, n_bad = 0, cyc = 0;
    bit    mode_async = 1'b0;
    int    q_cyc[$];
    logic [4:0] q_mask[$];
    string q_tag[$];

    irq_pin_qual dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ack_load(ack_load), .ack_level(ack_level),
        .irq_pend(irq_pend), .ext_req_pulse(ext_req_pulse),
        .p3_pull_low(p3_pull_low), .local_num(local_num)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: compare pulses against the queue head for this cycle
    always @(negedge clk) begin
        if (rst_n) begin
            logic [4:0] obs, exp;
            string tag;
            bit have;
            obs = {ext_req_pulse, irq_pend};
            exp = '0; have = 1'b0; tag = "R4";
            if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
                exp = q_mask.pop_front();
                tag = q_tag.pop_front();
                void'(q_cyc.pop_front());
                have = 1'b1;
            end
            if (have || obs != 0) chk(obs == exp, tag, int'(obs), int'(exp));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: hold pins low for nlow cycles, raise and hold them, queue result
    task automatic drive_seq(input logic [3:0] pins, input int nlow,
                             input logic [4:0] exp, input string tag);
        @(negedge clk);
        pin_in = pin_in & ~pins;
        tick(nlow);
        pin_in = pin_in | pins;
        if (exp != 0) begin
            q_cyc.push_back(cyc + (mode_async ? 4 : 2));
            q_mask.push_back(exp);
            q_tag.push_back(tag);
        end
        tick(8);
    endtask

    task automatic write_ctrl(input logic [2:0] d);
        @(negedge clk);
        ctrl_we = 1'b1; ctrl_wdata = d;
        @(negedge clk);
        ctrl_we = 1'b0;
        mode_async = d[0];
        tick(3);
    endtask

    task automatic ack_write(input logic lvl);
        @(negedge clk);
        ack_load = 1'b1; ack_level = lvl;
        @(negedge clk);
        ack_load = 1'b0;
    endtask

    task automatic do_reset(input logic p0);
        @(negedge clk);
        rst_n = 1'b0; pin_in[0] = p0;
        tick(3);
        rst_n = 1'b1;
        mode_async = 1'b0;
        tick(2);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pin_in = 4'hF; ctrl_we = 1'b0; ctrl_wdata = '0;
        ack_load = 1'b0; ack_level = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        chk(irq_pend == 0, "R1", irq_pend, 0);
        chk(ext_req_pulse == 0, "R1", ext_req_pulse, 0);
        chk(p3_pull_low == 0, "R1", p3_pull_low, 0);
        chk(local_num == 0, "R10", local_num, 0);

        // R2: synchronous single low sample then rise
        drive_seq(4'b0001, 1, 5'b00001, "R2");
        // R4: pin held high gives no second pulse (monitor flags any)
        tick(6);
        drive_seq(4'b0010, 3, 5'b00010, "R2");
        // R11: two pins together
        drive_seq(4'b0011, 1, 5'b00011, "R11");

        // R6 / R3: asynchronous mode
        write_ctrl(3'b001);
        drive_seq(4'b0001, 1, 5'b00000, "R3");
        drive_seq(4'b0001, 2, 5'b00001, "R3");
        // R3: armed pin, one high sample, one low, then held high
        @(negedge clk);
        pin_in[1] = 1'b0; tick(2);
        pin_in[1] = 1'b1; tick(1);
        pin_in[1] = 1'b0; tick(1);
        pin_in[1] = 1'b1;
        q_cyc.push_back(cyc + 4); q_mask.push_back(5'b00010); q_tag.push_back("R3");
        tick(8);

        // R7: pin 2 as controller request, then back to generic
        write_ctrl(3'b011);
        drive_seq(4'b0100, 2, 5'b10000, "R7");
        write_ctrl(3'b001);
        drive_seq(4'b0100, 2, 5'b00100, "R7");

        // R8: pin 3 in acknowledge role stays silent
        write_ctrl(3'b100);
        drive_seq(4'b1000, 2, 5'b00000, "R8");
        // R9: latched acknowledge drive
        ack_write(1'b1);
        chk(p3_pull_low == 1, "R9", p3_pull_low, 1);
        ack_level = 1'b0; tick(3);
        chk(p3_pull_low == 1, "R9", p3_pull_low, 1);
        ack_write(1'b0);
        chk(p3_pull_low == 0, "R9", p3_pull_low, 0);
        ack_write(1'b1);
        chk(p3_pull_low == 1, "R9", p3_pull_low, 1);
        write_ctrl(3'b000);
        chk(p3_pull_low == 0, "R9", p3_pull_low, 0);
        // R8: pin 3 qualifies again as input
        drive_seq(4'b1000, 1, 5'b01000, "R8");

        // R10: strap low gives secondary number, pin 0 then qualifies
        do_reset(1'b0);
        chk(local_num == 1, "R10", local_num, 1);
        pin_in[0] = 1'b1;
        q_cyc.push_back(cyc + 2); q_mask.push_back(5'b00001); q_tag.push_back("R10");
        tick(8);
        chk(local_num == 1, "R10", local_num, 1);
        do_reset(1'b1);
        chk(local_num == 0, "R10", local_num, 0);
        tick(4);

        chk(q_cyc.size() == 0, "R4", q_cyc.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule